// File: doc/BRIEF.md
# Paged Microcode Address Sequencer

This block drives the address of a microcode store and holds the 24-bit control word read back from it. The address has three fields. The top field is the instruction-set page. The middle field is the opcode of the instruction now executing. The bottom field is a step counter within that opcode's run of sixteen microinstructions. The page register is written from microcode. This lets a running machine switch between two or more instruction-set personalities: the next opcode fetched is decoded under the newly chosen page.

Instructions may be of any length up to sixteen steps. A long operation done in microcode simply uses more steps. The word being fetched in the current cycle carries an end-of-instruction flag. That flag, or reaching the last step of the run, closes the instruction at the next clock edge. At that edge the opcode byte presented by memory is captured, the step returns to zero and any pending page change is applied. The store sits outside the block. It receives the address directly from the state registers, and its read data returns in the same cycle.

Top module: `paged_useq`

## Requirements
- R1: `ucode_addr` is 16 bits, with page in bits 15:12, opcode in bits 11:4 and step in bits 3:0.
- R2: When `uword_end` is low and the step is below 15, the step rises by one at each clock edge while page and opcode hold.
- R3: When `uword_end` is high, the next edge clears the step to 0 and loads `op_byte` as the new opcode; `op_byte` has no effect in any other cycle.
- R4: A page write (`page_wr` high with `page_val`) made in a non-final step of an instruction leaves the page field of `ucode_addr` unchanged until the instruction ends.
- R5: A page write in the same cycle as `uword_end` takes effect at that boundary, so the new opcode is addressed under the written page.
- R6: When several page writes occur within one instruction, the last one is applied at the boundary.
- R7: At step 15 without `uword_end`, the next edge still ends the instruction: step 0, `op_byte` loaded, pending page applied.
- R8: `ctrl_word` shows, after each edge, the value that was on `ucode_rdata` during the previous cycle.
- R9: Driving `rst_n` low forces `ucode_addr` to 0x0000 (page 0, fetch opcode 0x00, step 0) and `ctrl_word` to 0 without waiting for a clock. After `rst_n` rises, the state first advances on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_byte | input | 8 | Opcode byte fetched from memory |
| page_wr | input | 1 | Page-select write strobe from microcode |
| page_val | input | 4 | Page number to be written |
| uword_end | input | 1 | End-of-instruction flag of the word fetched this cycle |
| ucode_rdata | input | 24 | Word returned by the microcode store |
| ucode_addr | output | 16 | Microcode store address |
| ctrl_word | output | 24 | Latched control word |

## Verification
Every decision the sequencer makes appears on `ucode_addr` exactly one edge after the inputs that caused it. This covers a step advance, an opcode capture, and a page swap at a boundary. `ctrl_word` also lags the store data by that one edge. The bench therefore drives inputs on the falling edge, lets one rising edge pass, and samples both outputs on the following falling edge. It compares the address against a hand-computed vector and the word against the store model's value for the previously expected address. The reset path is checked twice: once with no clock, for the asynchronous clear, and again on each of the two edges after release, where the address must still be 0x0000, before the first advance on the third edge.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int PAGE_W = 4;
  localparam int OP_W   = 8;
  localparam int STEP_W = 4;
  localparam int WORD_W = 24;
  localparam int ADDR_W = PAGE_W + OP_W + STEP_W;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [OP_W-1:0]   op;
    logic [STEP_W-1:0] step;
  } uaddr_t;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/useq_step_ctl.sv
module useq_step_ctl #(
  parameter int OP_W   = 8,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              end_i,
  input  logic [OP_W-1:0]   op_byte_i,
  output logic [OP_W-1:0]   op_o,
  output logic [STEP_W-1:0] step_o,
  output logic              bnd_o
);
  localparam logic [STEP_W-1:0] STEP_LAST = '1;
  localparam logic [STEP_W-1:0] STEP_ONE  = STEP_W'(1);

  logic [OP_W-1:0]   op_q, op_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              op_en;
  logic              bnd;

  always_comb begin
    bnd    = end_i | (step_q == STEP_LAST);
    op_en  = bnd;
    step_d = bnd ? '0 : (step_q + STEP_ONE);
    op_d   = op_en ? op_byte_i : op_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      op_q   <= '0;
    end else begin
      step_q <= step_d;
      if (op_en) op_q <= op_d;
    end
  end

  assign op_o   = op_q;
  assign step_o = step_q;
  assign bnd_o  = bnd;

  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_ni)
    (!end_i && step_q != STEP_LAST) |=> (step_q == $past(step_q) + STEP_ONE)); // R2
  AST_STEP_CLR_END: assert property (@(posedge clk) disable iff (!rst_ni)
    end_i |=> (step_q == '0)); // R3
  AST_STEP_CLR_LAST: assert property (@(posedge clk) disable iff (!rst_ni)
    (step_q == STEP_LAST) |=> (step_q == '0)); // R7
  AST_OP_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    end_i |=> (op_q == $past(op_byte_i))); // R3
  AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!end_i && step_q != STEP_LAST) |=> $stable(op_q)); // R3
endmodule

// File: rtl/useq_page_ctl.sv
module useq_page_ctl #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bnd_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wval_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [PAGE_W-1:0] pend_q, pend_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              pend_en;
  logic              page_en;

  always_comb begin
    pend_en = wr_i;
    pend_d  = pend_en ? wval_i : pend_q;
    page_en = bnd_i;
    page_d  = pend_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      page_q <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (page_en) page_q <= page_d;
    end
  end

  assign page_o = page_q;

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !bnd_i |=> $stable(page_q)); // R4
  AST_PAGE_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (bnd_i && wr_i) |=> (page_q == $past(wval_i))); // R5
endmodule

// File: rtl/paged_useq.sv
module paged_useq
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_byte,
  input  logic              page_wr,
  input  logic [PAGE_W-1:0] page_val,
  input  logic              uword_end,
  input  logic [WORD_W-1:0] ucode_rdata,
  output logic [ADDR_W-1:0] ucode_addr,
  output logic [WORD_W-1:0] ctrl_word
);
  logic              rst_ni;
  logic              bnd;
  logic [OP_W-1:0]   op;
  logic [STEP_W-1:0] step;
  logic [PAGE_W-1:0] page;
  uaddr_t            addr;
  logic [WORD_W-1:0] word_q, word_d;
  logic              word_en;

  useq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  useq_step_ctl #(.OP_W(OP_W), .STEP_W(STEP_W)) u_step (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .end_i     (uword_end),
    .op_byte_i (op_byte),
    .op_o      (op),
    .step_o    (step),
    .bnd_o     (bnd)
  );

  useq_page_ctl #(.PAGE_W(PAGE_W)) u_page (
    .clk    (clk),
    .rst_ni (rst_ni),
    .bnd_i  (bnd),
    .wr_i   (page_wr),
    .wval_i (page_val),
    .page_o (page)
  );

  always_comb begin
    addr.page = page;
    addr.op   = op;
    addr.step = step;
    word_en   = 1'b1;
    word_d    = ucode_rdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign ucode_addr = addr;
  assign ctrl_word  = word_q;

  AST_ADDR_RESET: assert property (@(posedge clk)
    !rst_ni |-> (ucode_addr == '0)); // R9
  AST_WORD_RESET: assert property (@(posedge clk)
    !rst_ni |-> (ctrl_word == '0)); // R9
endmodule

// File: tb/sim_paged_useq.sv
module sim_paged_useq;
  logic        clk;
  logic        rst_n;
  logic [7:0]  op_byte;
  logic        page_wr;
  logic [3:0]  page_val;
  logic        uword_end;
  logic [23:0] ucode_rdata;
  logic [15:0] ucode_addr;
  logic [23:0] ctrl_word;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Store model: bit 23 marks the final step, bits 15:0 echo the address.
  function automatic logic [23:0] rom_word(input logic [15:0] a);
    logic [2:0] last;
    logic       fin;
    last = a[6:4] + a[14:12];
    fin  = (a[11:4] != 8'hFF) && (a[3:0] == {1'b0, last});
    return {fin, 7'h00, a};
  endfunction

  assign ucode_rdata = rom_word(ucode_addr);
  assign uword_end   = ucode_rdata[23];

  paged_useq u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_byte     (op_byte),
    .page_wr     (page_wr),
    .page_val    (page_val),
    .uword_end   (uword_end),
    .ucode_rdata (ucode_rdata),
    .ucode_addr  (ucode_addr),
    .ctrl_word   (ctrl_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {op_byte, page_wr, page_val, pad, expected address after the edge}
  localparam logic [31:0] VEC [8] = '{
    {8'h12, 1'b0, 4'h0, 3'b0, 16'h0120},
    {8'h34, 1'b0, 4'h0, 3'b0, 16'h0121},
    {8'h55, 1'b1, 4'h3, 3'b0, 16'h0122},
    {8'h05, 1'b0, 4'h0, 3'b0, 16'h3050},
    {8'h40, 1'b1, 4'h9, 3'b0, 16'h9400},
    {8'h00, 1'b0, 4'h0, 3'b0, 16'h9401},
    {8'hFF, 1'b0, 4'h0, 3'b0, 16'h9FF0},
    {8'h22, 1'b0, 4'h0, 3'b0, 16'h9FF1}
  };

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    rst_n = 1'b0; op_byte = '0; page_wr = 1'b0; page_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset addr", {8'h0, ucode_addr}, 24'h000000);
    chk("R9 reset word", ctrl_word, 24'h000000);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R8
    prev = 16'h0000;
    for (int i = 0; i < 8; i++) begin
      op_byte  = VEC[i][31:24];
      page_wr  = VEC[i][23];
      page_val = VEC[i][22:19];
      @(posedge clk);
      @(negedge clk);
      chk("R1/R2/R3/R4/R5 addr", {8'h0, ucode_addr}, {8'h0, VEC[i][15:0]});
      chk("R8 word", ctrl_word, rom_word(prev));
      prev = VEC[i][15:0];
    end

    // Long run to the last step; two page writes, the later one wins (R6)
    for (int s = 2; s < 16; s++) begin
      op_byte  = 8'h22;
      page_wr  = (s == 4) || (s == 6);
      page_val = (s == 4) ? 4'h6 : 4'h0;
      @(posedge clk);
      @(negedge clk);
      chk("R2 long step", {8'h0, ucode_addr}, {8'h0, 4'h9, 8'hFF, 4'(s)});
      chk("R4 page held", {20'h0, ucode_addr[15:12]}, 24'h000009);
    end
    page_wr = 1'b0;
    op_byte = 8'h22;
    @(posedge clk);
    @(negedge clk);
    chk("R7 forced boundary", {8'h0, ucode_addr}, 24'h000220);
    chk("R6 last write wins", {20'h0, ucode_addr[15:12]}, 24'h000000);
    chk("R8 word at step 15", ctrl_word, 24'h009FFF);

    // Asynchronous reset with no clock edge
    #2 rst_n = 1'b0;
    #2;
    chk("R9 async addr", {8'h0, ucode_addr}, 24'h000000);
    chk("R9 async word", ctrl_word, 24'h000000);
    @(negedge clk);
    rst_n   = 1'b1;
    op_byte = 8'h77;
    @(posedge clk); @(negedge clk);
    chk("R9 release edge 1", {8'h0, ucode_addr}, 24'h000000);
    @(posedge clk); @(negedge clk);
    chk("R9 release edge 2", {8'h0, ucode_addr}, 24'h000000);
    @(posedge clk); @(negedge clk);
    chk("R9 R3 first advance", {8'h0, ucode_addr}, 24'h000770);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule